// File: doc/BRIEF.md
# Queued Pairwise Adder Peripheral

This block is a memory-mapped slave that adds pairs of 32-bit numbers. It has no per-operand registers. Software or a DMA engine streams operands into one write address. The block sorts them into an x queue and a y queue, alternating between the two. An internal core takes one x and one y whenever both are waiting and the sum queue has room, adds them modulo 2^32, and queues the sum. Sums are drained from one read address in the order their operand pairs arrived.

Everything runs on one clock. Each queue protects itself: a push to a full queue and a pop from an empty queue are dropped without disturbing the stored words. The fill level of each queue can be read, so a driver can size its bursts. Queue depth is a parameter: the default is 8, and settings of many thousands of words are allowed.

The operand router is a two-state machine. `SEL_X` moves to `SEL_Y` on an accepted operand write, and `SEL_Y` moves back to `SEL_X` on an accepted operand write. A rejected write leaves the state unchanged. The core is a two-state machine. `CORE_IDLE` moves to `CORE_HOLD` when both input queues are non-empty and the sum queue is not full; on that move it pops both input queues and captures the sum. `CORE_HOLD` always returns to `CORE_IDLE` and pushes the captured sum.

Top module: `stream_adder_periph`

## Requirements
- R1: After reset all three fill levels read zero, `rdata` is zero, and the first operand write goes to the x queue.
- R2: Accepted writes to address 0 go to the x queue and the y queue in turn, starting with x. The fill levels are read at address 2 (x), address 3 (y) and address 4 (sums), zero-extended to 32 bits.
- R3: A write to address 0 whose target queue is full is dropped. The fill level and contents of that queue do not change, and the next write still targets the same queue.
- R4: The core pops one x and one y together and pushes x+y modulo 2^32 into the sum queue.
- R5: The core moves no data while either input queue is empty or the sum queue is full.
- R6: Sums are read out in the same order in which their operand pairs were written.
- R7: A read of address 1 with a non-empty sum queue returns the oldest sum on `rdata` one cycle after the strobe and removes that sum.
- R8: A read of address 1 with an empty sum queue returns zero and changes no state.
- R9: The fill levels read at addresses 2, 3 and 4 match the number of words held in each queue.
- R10: With `cs` low, `wr` and `rd` have no effect.
- R11: The sum queue fill level rises by at most one per clock, because the core completes at most one addition per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| cs | input | 1 | Slave select |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered, holds between reads |

## Verification
The hardest condition to reach is the full-stall state. In that state both operand queues and the sum queue are full at once, the core is blocked by back-pressure, and the router still sits on the x queue. The stimulus reaches it by streaming twice the queue depth of operand pairs without reading any sums. It then writes once more to confirm the write is dropped. Finally it drains a single sum and writes a new pair, which shows that the router's state survived the rejected write and that pairing stays aligned.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam int ADDR_OPERAND = 0;
    localparam int ADDR_RESULT  = 1;
    localparam int ADDR_XLEVEL  = 2;
    localparam int ADDR_YLEVEL  = 3;
    localparam int ADDR_RLEVEL  = 4;

    typedef enum logic {SEL_X = 1'b0, SEL_Y = 1'b1} sel_e;
    typedef enum logic {CORE_IDLE = 1'b0, CORE_HOLD = 1'b1} core_e;
endpackage

// File: rtl/sap_queue.sv
module sap_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/sap_core.sv
module sap_core
    import sap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_empty,
    input  logic              y_empty,
    input  logic              r_full,
    input  logic [DATA_W-1:0] x_head,
    input  logic [DATA_W-1:0] y_head,
    output logic              pop_xy,
    output logic              push_r,
    output logic [DATA_W-1:0] sum
);
    core_e state, state_nxt;
    logic  can_fire;

    assign can_fire = !x_empty && !y_empty && !r_full;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CORE_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        pop_xy    = 1'b0;
        push_r    = 1'b0;
        unique case (state)
            CORE_IDLE: begin
                if (can_fire) begin
                    pop_xy    = 1'b1;
                    state_nxt = CORE_HOLD;
                end
            end
            CORE_HOLD: begin
                push_r    = 1'b1;
                state_nxt = CORE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sum <= '0;
        else if (pop_xy) sum <= x_head + y_head;
    end
endmodule

// File: rtl/sap_front.sv
module sap_front
    import sap_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic              x_full,
    input  logic              y_full,
    input  logic              r_empty,
    input  logic [DATA_W-1:0] r_head,
    input  logic [CW-1:0]     x_level,
    input  logic [CW-1:0]     y_level,
    input  logic [CW-1:0]     r_level,
    output logic              push_x,
    output logic              push_y,
    output logic              pop_r,
    output logic [DATA_W-1:0] rdata
);
    sel_e sel, sel_nxt;
    logic wr_op;
    logic rd_any;

    assign wr_op  = cs && wr && (addr == ADDR_W'(ADDR_OPERAND));
    assign rd_any = cs && rd;
    assign pop_r  = rd_any && (addr == ADDR_W'(ADDR_RESULT)) && !r_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) sel <= SEL_X;
        else        sel <= sel_nxt;
    end

    always_comb begin
        sel_nxt = sel;
        push_x  = 1'b0;
        push_y  = 1'b0;
        unique case (sel)
            SEL_X: begin
                if (wr_op && !x_full) begin
                    push_x  = 1'b1;
                    sel_nxt = SEL_Y;
                end
            end
            SEL_Y: begin
                if (wr_op && !y_full) begin
                    push_y  = 1'b1;
                    sel_nxt = SEL_X;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_any) begin
            unique case (addr)
                ADDR_W'(ADDR_RESULT): rdata <= r_empty ? '0 : r_head;
                ADDR_W'(ADDR_XLEVEL): rdata <= DATA_W'(x_level);
                ADDR_W'(ADDR_YLEVEL): rdata <= DATA_W'(y_level);
                ADDR_W'(ADDR_RLEVEL): rdata <= DATA_W'(r_level);
                default:              rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/stream_adder_periph.sv
module stream_adder_periph
    import sap_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata
);
    logic              push_x, push_y, pop_xy, push_r, pop_r;
    logic              x_full, y_full, r_full, x_empty, y_empty, r_empty;
    logic [DATA_W-1:0] x_head, y_head, r_head, sum;
    logic [CW-1:0]     x_level, y_level, r_level;

    sap_front #(.CW(CW)) u_front (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .wr(wr), .rd(rd),
        .x_full(x_full), .y_full(y_full), .r_empty(r_empty), .r_head(r_head),
        .x_level(x_level), .y_level(y_level), .r_level(r_level),
        .push_x(push_x), .push_y(push_y), .pop_r(pop_r), .rdata(rdata)
    );

    sap_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_xq (
        .clk(clk), .rst_n(rst_n), .push(push_x), .din(wdata), .pop(pop_xy),
        .head(x_head), .level(x_level), .full(x_full), .empty(x_empty)
    );

    sap_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_yq (
        .clk(clk), .rst_n(rst_n), .push(push_y), .din(wdata), .pop(pop_xy),
        .head(y_head), .level(y_level), .full(y_full), .empty(y_empty)
    );

    sap_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_rq (
        .clk(clk), .rst_n(rst_n), .push(push_r), .din(sum), .pop(pop_r),
        .head(r_head), .level(r_level), .full(r_full), .empty(r_empty)
    );

    sap_core u_core (
        .clk(clk), .rst_n(rst_n), .x_empty(x_empty), .y_empty(y_empty),
        .r_full(r_full), .x_head(x_head), .y_head(y_head),
        .pop_xy(pop_xy), .push_r(push_r), .sum(sum)
    );
endmodule

// File: rtl/sap_chk.sv
module sap_chk
    import sap_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cs,
    input logic              rd,
    input logic [DATA_W-1:0] rdata,
    input logic [CW-1:0]     x_level,
    input logic [CW-1:0]     y_level,
    input logic [CW-1:0]     r_level,
    input logic              pop_xy,
    input logic              push_r,
    input logic              push_x,
    input logic              push_y,
    input logic [DATA_W-1:0] r_head
);
    logic rd_res;
    assign rd_res = cs && rd && (addr == ADDR_W'(ADDR_RESULT));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (x_level <= CW'(DEPTH)) && (y_level <= CW'(DEPTH)) && (r_level <= CW'(DEPTH)));

    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_x && push_y));

    a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_xy |-> (x_level != '0) && (y_level != '0));

    a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_r |-> (r_level != CW'(DEPTH)));

    a_r11_one_add: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, r_level} <= {1'b0, $past(r_level)} + 1'b1));

    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res && r_level == '0) |=> (rdata == '0));

    a_r7_head_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_res && r_level != '0) |=> (rdata == $past(r_head)));
endmodule

bind stream_adder_periph sap_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .rd(rd), .rdata(rdata),
    .x_level(x_level), .y_level(y_level), .r_level(r_level),
    .pop_xy(pop_xy), .push_r(push_r), .push_x(push_x), .push_y(push_y),
    .r_head(r_head)
);

// File: tb/sim_stream_adder_periph.sv
module sim_stream_adder_periph;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;
    logic [31:0] expq [64];
    int exp_wr = 0;
    int exp_rd = 0;

    stream_adder_periph #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .wr(wr),
        .wdata(wdata), .rd(rd), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic sel = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; cs = sel; wr = 1'b1;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d, input logic sel = 1'b1);
        @(negedge clk);
        addr = a; cs = sel; rd = 1'b1;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_levels(input string req, input int xl, input int yl, input int rl);
        logic [31:0] v;
        bus_read(3'd2, v); check({req, " x level"}, v, 32'(xl));
        bus_read(3'd3, v); check({req, " y level"}, v, 32'(yl));
        bus_read(3'd4, v); check({req, " sum level"}, v, 32'(rl));
    endtask

    task automatic push_pair(input logic [31:0] a, input logic [31:0] b);
        bus_write(3'd0, a);
        bus_write(3'd0, b);
        expq[exp_wr] = a + b;
        exp_wr++;
    endtask

    task automatic pop_sum(input string req);
        logic [31:0] v;
        bus_read(3'd1, v);
        check(req, v, expq[exp_rd]);
        exp_rd++;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata after reset", rdata, 32'h0);
        check_levels("R1", 0, 0, 0);

        // R8 empty read
        bus_read(3'd1, v);
        check("R8 empty read", v, 32'h0);
        check_levels("R8", 0, 0, 0);

        // R2/R5: lone x, core must stall
        bus_write(3'd0, 32'h0000_1234);
        idle(6);
        check_levels("R2 R5 lone x", 1, 0, 0);
        bus_write(3'd0, 32'h0000_4321);
        expq[exp_wr] = 32'h0000_5555; exp_wr++;
        idle(6);
        check_levels("R4", 0, 0, 1);
        pop_sum("R7 first sum");
        check_levels("R7 popped", 0, 0, 0);

        // R4/R6 sweep: fill the sum queue, then both operand queues
        for (int i = 0; i < 2*DEPTH; i++) begin
            logic [31:0] a, b;
            a = (i == 0) ? 32'hFFFF_FFFF : (32'(i) * 32'h0123_4567) ^ 32'hA5A5_0000;
            b = (i == 0) ? 32'h0000_0001 : ~a + 32'(i * 3);
            push_pair(a, b);
        end
        idle(10);
        check_levels("R5 full stall", DEPTH, DEPTH, DEPTH);

        // R3: drop write to full x queue
        bus_write(3'd0, 32'hDEAD_BEEF);
        idle(4);
        check_levels("R3 dropped", DEPTH, DEPTH, DEPTH);

        pop_sum("R4 R6 wrap sum");
        idle(6);
        check_levels("R5 refill", DEPTH-1, DEPTH-1, DEPTH);
        bus_write(3'd0, 32'h1111_0000);
        check_levels("R3 toggle held", DEPTH, DEPTH-1, DEPTH);
        bus_write(3'd0, 32'h0000_2222);
        expq[exp_wr] = 32'h1111_2222; exp_wr++;
        check_levels("R2 y after x", DEPTH, DEPTH, DEPTH);

        // R10: no effect without cs
        bus_write(3'd0, 32'h5A5A_5A5A, 1'b0);
        bus_read(3'd1, v, 1'b0);
        check_levels("R10 unselected", DEPTH, DEPTH, DEPTH);

        while (exp_rd < exp_wr) begin
            pop_sum("R6 order");
            idle(2);
        end
        idle(4);
        check_levels("R9 drained", 0, 0, 0);
        bus_read(3'd1, v);
        check("R8 empty after drain", v, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule